// File: doc/BRIEF.md
# Short Backward Branch Loop Folder

This block watches the retirement stream of a simple in-order core and recognises small loops closed by an ordinary PC-relative branch that jumps backwards by a short distance. No special loop opcode is needed. When such a branch retires taken, its negative displacement is loaded into a small up-counter. The counter then advances once for each instruction that retires in sequence inside the loop body.

When the counter reaches the end of the body, the block knows that the next instruction would be the closing branch. It raises a one-cycle redirect that carries the loop-start address, so fetch can skip the branch and go straight back to the top of the loop. The branch still retires later with its real outcome. That outcome decides whether folding continues. Folding is abandoned when:

- the loop branch resolves not-taken,
- any other taken branch retires,
- an exception or other flow change is reported, or
- the instruction after a redirect is not the loop branch.

The block only observes retirement and drives a redirect hint. Decode and the fetch unit are outside it.

Top module: `sbb_loop_folder`

## Requirements
- R1: After reset, `fold_active` and `redir_vld` are both 0.
- R2: A retiring branch counts as a short backward branch when its signed displacement lies between -2^(CNT_W-1) and -1 inclusive (-16..-1 by default). A taken short backward branch with `flow_chg` low sets `fold_active` to 1 in the cycle after it retires. A taken branch with displacement 0, a positive displacement, or a displacement below -2^(CNT_W-1) never sets `fold_active`.
- R3: The retirement of the arming branch produces no redirect. While folding, `redir_vld` pulses high for exactly one cycle. The pulse comes in the cycle after the -disp-th sequential retirement following the arming branch, which is the retirement of the instruction just before the loop branch.
- R4: While `redir_vld` is high, `redir_pc` equals the arming branch's PC plus its sign-extended displacement, modulo 2^PC_W.
- R5: Cycles with `ret_vld` low and `flow_chg` low leave the fold state and the count unchanged, and produce no redirect.
- R6: A not-taken branch at a PC other than the loop branch's PC counts as one sequential instruction of the body.
- R7: When the loop branch (same PC as the arming branch) retires not-taken, `fold_active` is 0 from the next cycle, and no redirect is produced until a new short backward branch retires taken.
- R8: A taken branch that is not short cancels folding. A taken short backward branch at a different PC re-arms the block on the new loop, replacing the target and the count.
- R9: `flow_chg` high cancels folding in the next cycle, whatever retires in the same cycle, and it blocks arming and redirect in that cycle.
- R10: After a redirect, if the next retirement is anything other than a taken short backward branch, folding is cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_vld | input | 1 | One instruction retires this cycle |
| ret_br | input | 1 | Retiring instruction is a PC-relative branch |
| ret_taken | input | 1 | Retiring branch resolved taken |
| ret_disp | input | DISP_W | Signed branch displacement, in instructions |
| ret_pc | input | PC_W | Instruction address of the retiring instruction |
| flow_chg | input | 1 | Exception or other non-branch flow change |
| fold_active | output | 1 | A loop is being tracked |
| redir_vld | output | 1 | One-cycle redirect to loop start |
| redir_pc | output | PC_W | Redirect target, valid with `redir_vld` |

## Verification
The bench replays scripted instruction traces and compares redirect timing against a loop model that knows where each body ends. It covers the extremes of loop length:

- A one-instruction body at displacement -1 exposes an off-by-one in the end-of-count test, which would fire a cycle late or never.
- A displacement of -16 and a rejected -17 would break if the range test used the wrong bit slice.

Retirement gaps and not-taken inner branches would shift the redirect if idle cycles were counted or inner branches were treated as loop exits. Other traces cover exit by a not-taken loop branch, a taken long branch, a flow change, an unexpected instruction after a redirect, and re-arming on a nested short loop. A design that ignored any of these would send fetch back to a stale target.

// File: rtl/sbbf_pkg.sv
package sbbf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_COUNT = 2'd1,
    FS_WAIT  = 2'd2
  } fold_state_e;

endpackage

// File: rtl/sbbf_classify.sv
// Classifies the retiring instruction: taken short backward branch
// (arms a loop) or any other taken branch (cancels a loop).
module sbbf_classify #(
  parameter int DISP_W = 12,
  parameter int CNT_W  = 5,
  localparam int HI_W  = DISP_W - CNT_W + 1
) (
  input  logic            ret_vld,
  input  logic            ret_br,
  input  logic            ret_taken,
  input  logic [HI_W-1:0] disp_hi,
  output logic            is_short,
  output logic            arm,
  output logic            other_taken
);

  // Upper bits all ones <=> -2^(CNT_W-1) <= disp <= -1.
  always_comb begin
    is_short    = ret_br && (&disp_hi);
    arm         = ret_vld && ret_taken && is_short;
    other_taken = ret_vld && ret_br && ret_taken && !is_short;
  end

endmodule

// File: rtl/sbbf_counter.sv
// Body up-counter: loaded with the negative displacement, steps toward
// zero, reports the last body instruction at all-ones.
module sbbf_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || inc || clr;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign at_last = &cnt_q;

endmodule

// File: rtl/sbbf_ctrl.sv
// Fold state machine, loop registers and redirect output stage.
module sbbf_ctrl
  import sbbf_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_vld,
  input  logic              ret_br,
  input  logic [PC_W-1:0]   ret_pc,
  input  logic [DISP_W-1:0] ret_disp,
  input  logic              flow_chg,
  input  logic              arm,
  input  logic              other_taken,
  input  logic              at_last,
  output logic              cnt_load,
  output logic              cnt_inc,
  output logic              cnt_clr,
  output logic              fold_active,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc
);

  localparam int EXT_W = PC_W - DISP_W;

  fold_state_e     state_q, state_d;
  logic [PC_W-1:0] bpc_q, tgt_q, tgt_d;
  logic [PC_W-1:0] rpc_q;
  logic            rvld_q;
  logic            fire;
  logic            loop_en;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_inc  = 1'b0;
    cnt_clr  = 1'b0;
    fire     = 1'b0;
    if (flow_chg) begin
      state_d = FS_IDLE;
      cnt_clr = 1'b1;
    end else if (ret_vld) begin
      if (arm) begin
        state_d  = FS_COUNT;
        cnt_load = 1'b1;
      end else if (other_taken) begin
        state_d = FS_IDLE;
        cnt_clr = 1'b1;
      end else begin
        unique case (state_q)
          FS_COUNT: begin
            if (ret_br && (ret_pc == bpc_q)) begin
              state_d = FS_IDLE;
              cnt_clr = 1'b1;
            end else if (at_last) begin
              fire    = 1'b1;
              state_d = FS_WAIT;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end
          FS_WAIT: begin
            state_d = FS_IDLE;
            cnt_clr = 1'b1;
          end
          default: begin
            state_d = FS_IDLE;
          end
        endcase
      end
    end
  end

  always_comb begin
    loop_en = cnt_load;
    tgt_d   = ret_pc + {{EXT_W{ret_disp[DISP_W-1]}}, ret_disp};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      rvld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rvld_q  <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpc_q <= '0;
      tgt_q <= '0;
    end else if (loop_en) begin
      bpc_q <= ret_pc;
      tgt_q <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpc_q <= '0;
    end else if (fire) begin
      rpc_q <= tgt_q;
    end
  end

  assign fold_active = (state_q != FS_IDLE);
  assign redir_vld   = rvld_q;
  assign redir_pc    = rpc_q;

endmodule

// File: rtl/sbb_loop_folder.sv
module sbb_loop_folder #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_vld,
  input  logic              ret_br,
  input  logic              ret_taken,
  input  logic [DISP_W-1:0] ret_disp,
  input  logic [PC_W-1:0]   ret_pc,
  input  logic              flow_chg,
  output logic              fold_active,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc
);

  localparam int HI_W = DISP_W - CNT_W + 1;

  logic             is_short, arm, other_taken;
  logic             cnt_load, cnt_inc, cnt_clr, at_last;
  logic [CNT_W-1:0] cnt;

  sbbf_classify #(.DISP_W(DISP_W), .CNT_W(CNT_W)) u_cls (
    .ret_vld     (ret_vld),
    .ret_br      (ret_br),
    .ret_taken   (ret_taken),
    .disp_hi     (ret_disp[DISP_W-1 -: HI_W]),
    .is_short    (is_short),
    .arm         (arm),
    .other_taken (other_taken)
  );

  sbbf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (ret_disp[CNT_W-1:0]),
    .inc      (cnt_inc),
    .clr      (cnt_clr),
    .cnt      (cnt),
    .at_last  (at_last)
  );

  sbbf_ctrl #(.PC_W(PC_W), .DISP_W(DISP_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_vld     (ret_vld),
    .ret_br      (ret_br),
    .ret_pc      (ret_pc),
    .ret_disp    (ret_disp),
    .flow_chg    (flow_chg),
    .arm         (arm),
    .other_taken (other_taken),
    .at_last     (at_last),
    .cnt_load    (cnt_load),
    .cnt_inc     (cnt_inc),
    .cnt_clr     (cnt_clr),
    .fold_active (fold_active),
    .redir_vld   (redir_vld),
    .redir_pc    (redir_pc)
  );

  // cnt and is_short are observation points for the checker
  logic unused_ok;
  assign unused_ok = ^{cnt, is_short};

endmodule

// File: rtl/sbb_loop_folder_chk.sv
module sbb_loop_folder_chk #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_vld,
  input logic              ret_br,
  input logic              ret_taken,
  input logic [DISP_W-1:0] ret_disp,
  input logic [PC_W-1:0]   ret_pc,
  input logic              flow_chg,
  input logic              fold_active,
  input logic              redir_vld,
  input logic [PC_W-1:0]   redir_pc
);

  logic disp_in_range;
  assign disp_in_range = (&ret_disp[DISP_W-1:CNT_W-1]);

  // R2
  arm_on_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && ret_br && ret_taken && disp_in_range && !flow_chg)
      |=> (fold_active && !redir_vld));

  // R3
  redir_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |=> !redir_vld);

  // R3
  redir_needs_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |-> fold_active);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_vld && !flow_chg) |=> ($stable(fold_active) && !redir_vld));

  // R8
  long_taken_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && ret_br && ret_taken && !disp_in_range && !flow_chg)
      |=> (!fold_active && !redir_vld));

  // R9
  flow_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_chg |=> (!fold_active && !redir_vld));

  // R4
  redir_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && $past(redir_vld)) |-> $stable(redir_pc));

endmodule

bind sbb_loop_folder sbb_loop_folder_chk #(
  .PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_br(ret_br),
  .ret_taken(ret_taken), .ret_disp(ret_disp), .ret_pc(ret_pc),
  .flow_chg(flow_chg), .fold_active(fold_active),
  .redir_vld(redir_vld), .redir_pc(redir_pc)
);

// File: tb/sbb_loop_folder_tb.sv
`timescale 1ns/1ps
module sbb_loop_folder_tb;

  localparam int PC_W   = 16;
  localparam int DISP_W = 12;
  localparam int CNT_W  = 5;

  logic              clk;
  logic              rst_n;
  logic              ret_vld, ret_br, ret_taken, flow_chg;
  logic [DISP_W-1:0] ret_disp;
  logic [PC_W-1:0]   ret_pc;
  logic              fold_active, redir_vld;
  logic [PC_W-1:0]   redir_pc;

  int n_chk  = 0;
  int n_fail = 0;

  sbb_loop_folder #(.PC_W(PC_W), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_br(ret_br),
    .ret_taken(ret_taken), .ret_disp(ret_disp), .ret_pc(ret_pc),
    .flow_chg(flow_chg), .fold_active(fold_active),
    .redir_vld(redir_vld), .redir_pc(redir_pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, sample 1 ns after the capturing edge.
  task automatic step(input bit v, input bit br, input bit tk,
                      input int pc, input int d, input bit fc);
    @(negedge clk);
    ret_vld   = v;
    ret_br    = br;
    ret_taken = tk;
    ret_pc    = pc[PC_W-1:0];
    ret_disp  = d[DISP_W-1:0];
    flow_chg  = fc;
    @(posedge clk);
    #1;
    ret_vld  = 1'b0;
    flow_chg = 1'b0;
  endtask

  function automatic int tgt(input int p, input int d);
    return (p + d) & ((1 << PC_W) - 1);
  endfunction

  task automatic clear_state();
    step(0, 0, 0, 0, 0, 1);
  endtask

  // One pass through the loop body P+d .. P-1.
  task automatic body(input int p, input int d, input bit exp_redir,
                      input int nt_at, input bit gap);
    for (int k = 0; k < -d; k++) begin
      if (k == nt_at) step(1, 1, 0, p + d + k, -2, 0);
      else            step(1, 0, 0, p + d + k, 0, 0);
      chk((k == nt_at) ? "R6" : "R3", redir_vld, (exp_redir && k == -d - 1) ? 1 : 0);
      if (exp_redir && k == -d - 1) chk("R4", redir_pc, tgt(p, d));
      if (gap) begin
        step(0, 0, 0, 0, 0, 0);
        chk("R5", redir_vld, 0);
        chk("R5", fold_active, exp_redir ? 1 : 0);
      end
    end
  endtask

  task automatic prime(input int p, input int d);
    body(p, d, 0, -1, 0);
    step(1, 1, 1, p, d, 0);
    chk("R2", fold_active, 1);
    chk("R3", redir_vld, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ret_vld = 0; ret_br = 0; ret_taken = 0;
    ret_pc = '0; ret_disp = '0; flow_chg = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", fold_active, 0);
    chk("R1", redir_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_loop(input int p, input int d, input int iters);
    prime(p, d);
    for (int i = 0; i < iters; i++) begin
      body(p, d, 1, -1, 0);
      step(1, 1, 1, p, d, 0);
      chk("R3", fold_active, 1);
    end
    body(p, d, 1, -1, 0);
    step(1, 1, 0, p, d, 0);
    chk("R7", fold_active, 0);
    body(p, d, 0, -1, 0);
    chk("R7", fold_active, 0);
  endtask

  task automatic t_range();
    step(1, 1, 1, 16'h0400, -17, 0);
    chk("R2", fold_active, 0);
    step(1, 1, 1, 16'h0400, 4, 0);
    chk("R2", fold_active, 0);
    step(1, 1, 1, 16'h0400, 0, 0);
    chk("R2", fold_active, 0);
  endtask

  task automatic t_gaps_inner();
    prime(16'h0500, -5);
    body(16'h0500, -5, 1, -1, 1);
    step(1, 1, 1, 16'h0500, -5, 0);
    body(16'h0500, -5, 1, 2, 0);
    clear_state();
  endtask

  task automatic t_long_taken();
    prime(16'h0600, -6);
    step(1, 0, 0, 16'h05FA, 0, 0);
    step(1, 1, 1, 16'h05FB, 40, 0);
    chk("R8", fold_active, 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 16'h05FC + k, 0, 0);
      chk("R8", redir_vld, 0);
    end
  endtask

  task automatic t_flow();
    prime(16'h0700, -4);
    step(1, 0, 0, 16'h06FC, 0, 0);
    step(1, 0, 0, 16'h06FD, 0, 1);
    chk("R9", fold_active, 0);
    step(1, 0, 0, 16'h06FE, 0, 0);
    step(1, 0, 0, 16'h06FF, 0, 0);
    chk("R9", redir_vld, 0);
    step(1, 1, 1, 16'h0700, -4, 1);
    chk("R9", fold_active, 0);
  endtask

  task automatic t_wrong_after_redir();
    prime(16'h0800, -3);
    body(16'h0800, -3, 1, -1, 0);
    step(1, 0, 0, 16'h0900, 0, 0);
    chk("R10", fold_active, 0);
    body(16'h0800, -3, 0, -1, 0);
  endtask

  task automatic t_rearm();
    prime(16'h0300, -8);
    step(1, 0, 0, 16'h02F8, 0, 0);
    step(1, 0, 0, 16'h02F9, 0, 0);
    step(1, 0, 0, 16'h02FA, 0, 0);
    step(1, 1, 1, 16'h02FB, -2, 0);
    chk("R8", fold_active, 1);
    step(1, 0, 0, 16'h02F9, 0, 0);
    chk("R8", redir_vld, 0);
    step(1, 0, 0, 16'h02FA, 0, 0);
    chk("R8", redir_vld, 1);
    chk("R8", redir_pc, 16'h02F9);
    clear_state();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_loop(16'h0100, -4, 3);
    t_loop(16'h0120, -1, 3);
    t_loop(16'h0140, -16, 2);
    t_loop(16'h0005, -10, 1);
    t_range();
    t_gaps_inner();
    t_long_taken();
    t_flow();
    t_wrong_after_redir();
    t_rearm();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule